// File: doc/BRIEF.md
# Endpoint Configuration Completer

This block sits in an endpoint function and answers Type 0 configuration reads and writes arriving as a stream of 32-bit header words. It decodes the three-word request header (plus one payload word for writes), checks that the request is well formed, and serves it from a small register store addressed by a 10-bit DW index. That index is built from the extended register number and the register number. A completion header, followed by one data word for a successful read, goes back out on a second word stream with valid/ready flow control.

After reset the function is not ready. Until the `dev_ready_i` input is seen high, or until a parameterised number of cycles has passed, it answers every request with retry status and no data, and no register changes. The function does not know its own bus and device numbers at reset. It learns them from the target fields of every well-formed Type 0 write it receives and places them in the completer ID of its completions.

Top module: `cfg_completer`

## Requirements
- R1: A request is framed from DW0. Fmt is bits [31:29] and Type is bits [28:24]. When Fmt bit 30 is set, one payload word follows the three header words, so a request is 4 words; otherwise it is 3. While a completion is being sent, `req_ready_o` is low. After reset, `req_ready_o` is high and `cpl_valid_o` is low.
- R2: A successful read (Fmt 000, Type 00100) returns 4 words. Word 0 is 0x4A000001. Word 1 is {completer ID[31:16], status[15:13], 0, byte count 12'd4}. Word 2 is {requester ID, tag, 0, lower address 7'd0}. Word 3 is the register value. `cpl_last_o` marks the final word.
- R3: A write (Fmt 010, Type 00100) returns 3 words: 0x0A000000, then words 1 and 2 laid out as in R2, with no data word.
- R4: Every completion copies the requester ID (DW1[31:16]) and the tag (DW1[15:8]) of its request into word 2.
- R5: Until ready, every request gets status 010 (retry) with no data word, and no register is written. Readiness is reached one cycle after `dev_ready_i` is sampled high, or no later than READY_CYCLES+1 cycles after reset is released. Once reached, it stays until the next reset.
- R6: A well-formed Type 0 write latches bus DW2[31:24] and device DW2[23:19]. This happens even when the write gets retry status. The completer ID is {bus, device, FUNC_NUM}, and the completion of that same write already carries the new values. Both numbers reset to 0.
- R7: For writes, first-DW byte enable bit b (DW1[3:0]) gates byte b of the register. All-zero enables change nothing and complete with status 000.
- R8: The DW index is {DW2[11:8], DW2[7:2]}. Indices 0–63 form the compatible region and 64–1023 the extended region. Index 0 returns ID_WORD and ignores writes. N_SCR scratch words sit at COMPAT_BASE and another N_SCR at EXT_BASE, and all scratch words reset to 0.
- R9: An index that maps to nothing reads as zero and ignores writes, with status 000.
- R10: Once ready, a request gets status 001 (UR) with no data word and no register or ID change when any of these hold: Length (DW0[9:0]) is not 1, last-DW byte enable (DW1[7:4]) is nonzero, TC (DW0[22:20]) is nonzero, or Fmt/Type is not a Type 0 config read or write. Retry status takes priority over UR.
- R11: While `cpl_valid_o` is high and `cpl_ready_i` is low, the completion word and `cpl_last_o` hold steady. No completion word appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_ready_i | input | 1 | Function ready; ends retry status early |
| req_dw_i | input | 32 | Request word |
| req_valid_i | input | 1 | Request word valid |
| req_ready_o | output | 1 | Request word accepted |
| cpl_dw_o | output | 32 | Completion word |
| cpl_valid_o | output | 1 | Completion word valid |
| cpl_last_o | output | 1 | Final word of a completion |
| cpl_ready_i | input | 1 | Completion word taken |

## Verification
The bench targets several corner cases, each tied to the fault it would expose:
- A write sent while the function is still not ready. A design that latched data during the retry window would later read back a modified scratch word. A design that skipped the ID latch would show a zero completer ID.
- Partial and all-zero byte enables on a word already holding a known pattern. These expose byte lanes that are swapped or written without their enable.
- Malformed requests aimed at a scratch word. A design that checked only some of the fields would modify that word or return data instead of UR.
- Writes to index 0, to an unmapped compatible index and to an unmapped extended index. These catch read-only and unmapped locations that wrongly take a write.
- A second reset with the ready input held high, to prove the early-ready path and that the ID clears.

Completions are drained under irregular backpressure throughout, so a word that changed while stalled would miscompare.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    CPL_SC  = 3'b000,
    CPL_UR  = 3'b001,
    CPL_CRS = 3'b010,
    CPL_CA  = 3'b100
  } cpl_status_e;

  typedef enum logic [1:0] {
    ST_RX,
    ST_EXEC,
    ST_TX
  } fsm_e;

  localparam logic [2:0] FMT_NODATA = 3'b000;
  localparam logic [2:0] FMT_DATA   = 3'b010;
  localparam logic [4:0] TYPE_CFG0  = 5'b00100;
  localparam logic [4:0] TYPE_CPL   = 5'b01010;
  localparam int         IDX_W      = 10;
endpackage

// File: rtl/cfg_ready_timer.sv
module cfg_ready_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
      if (force_i || cnt_q == LIMIT_C) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  // R5: readiness is sticky
  p_ready_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R5: the limit always forces readiness
  p_ready_at_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT_C) |=> ready_o);
  // R5: an asserted ready input is honoured the next cycle
  p_ready_forced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> ready_o);
endmodule

// File: rtl/cfg_scratch_bank.sv
module cfg_scratch_bank #(
  parameter int unsigned BASE  = 16,
  parameter int unsigned N     = 4,
  parameter int          IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic             hit_o,
  output logic [31:0]      rdata_o
);
  localparam int unsigned OW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][31:0] regs_q;
  logic [IDX_W-1:0]   off;
  logic [OW-1:0]      sel;

  assign off   = idx_i - IDX_W'(BASE);
  assign hit_o = (idx_i >= IDX_W'(BASE)) && (off < IDX_W'(N));
  assign sel   = off[OW-1:0];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(N); i++)
      if (hit_o && sel == OW'(i)) rdata_o = regs_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i && hit_o) begin
      for (int i = 0; i < int'(N); i++)
        if (sel == OW'(i))
          for (int b = 0; b < 4; b++)
            if (be_i[b]) regs_q[i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  // R7: empty byte enables leave the store untouched
  p_zero_be_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && be_i == 4'b0) |=> $stable(regs_q));
  // R9: writes outside the bank leave it untouched
  p_miss_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_o) |=> $stable(regs_q));
endmodule

// File: rtl/cfg_completer.sv
module cfg_completer
  import cfg_pkg::*;
#(
  parameter int unsigned READY_CYCLES = 1000,
  parameter logic [2:0]  FUNC_NUM     = 3'd0,
  parameter logic [31:0] ID_WORD      = 32'h5A17_0F3E,
  parameter int unsigned N_SCR        = 4,
  parameter int unsigned COMPAT_BASE  = 16,
  parameter int unsigned EXT_BASE     = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dev_ready_i,
  input  logic [31:0] req_dw_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  output logic [31:0] cpl_dw_o,
  output logic        cpl_valid_o,
  output logic        cpl_last_o,
  input  logic        cpl_ready_i
);
  localparam int N_BANK = 2;

  logic ready;
  cfg_ready_timer #(.LIMIT(READY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (dev_ready_i),
    .ready_o (ready)
  );

  fsm_e        state_q;
  logic [1:0]  rx_cnt_q, tx_cnt_q;
  logic [31:0] dw0_q, dw1_q, dw2_q, wdata_q, rdata_q;
  cpl_status_e status_q;
  logic        data_q;
  logic [7:0]  own_bus_q;
  logic [4:0]  own_dev_q;

  // request decode
  logic [2:0]       fmt, tc;
  logic [4:0]       typ;
  logic [9:0]       len;
  logic [3:0]       lbe, fbe;
  logic [IDX_W-1:0] idx;
  logic             is_rd, is_wr, malformed, wr_fire;
  cpl_status_e      exec_status;

  assign fmt = dw0_q[31:29];
  assign typ = dw0_q[28:24];
  assign tc  = dw0_q[22:20];
  assign len = dw0_q[9:0];
  assign lbe = dw1_q[7:4];
  assign fbe = dw1_q[3:0];
  assign idx = {dw2_q[11:8], dw2_q[7:2]};

  assign is_rd     = (fmt == FMT_NODATA) && (typ == TYPE_CFG0);
  assign is_wr     = (fmt == FMT_DATA) && (typ == TYPE_CFG0);
  assign malformed = !(is_rd || is_wr) || (len != 10'd1) || (lbe != 4'b0) || (tc != 3'b0);

  always_comb begin
    if (!ready)         exec_status = CPL_CRS;
    else if (malformed) exec_status = CPL_UR;
    else                exec_status = CPL_SC;
  end

  assign wr_fire = (state_q == ST_EXEC) && is_wr && (exec_status == CPL_SC);

  // register store: compatible and extended scratch banks
  logic [N_BANK-1:0]       bank_hit;
  logic [N_BANK-1:0][31:0] bank_rdata;
  logic [31:0]             rd_mux;

  for (genvar gb = 0; gb < N_BANK; gb++) begin : g_bank
    localparam int unsigned BASE = (gb == 0) ? COMPAT_BASE : EXT_BASE;
    cfg_scratch_bank #(.BASE(BASE), .N(N_SCR), .IDX_W(IDX_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_fire),
      .idx_i   (idx),
      .be_i    (fbe),
      .wdata_i (wdata_q),
      .hit_o   (bank_hit[gb]),
      .rdata_o (bank_rdata[gb])
    );
  end

  always_comb begin
    if (idx == '0)       rd_mux = ID_WORD;
    else if (bank_hit[0]) rd_mux = bank_rdata[0];
    else if (bank_hit[1]) rd_mux = bank_rdata[1];
    else                  rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RX;
      rx_cnt_q  <= '0;
      tx_cnt_q  <= '0;
      dw0_q     <= '0;
      dw1_q     <= '0;
      dw2_q     <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      status_q  <= CPL_SC;
      data_q    <= 1'b0;
      own_bus_q <= '0;
      own_dev_q <= '0;
    end else begin
      unique case (state_q)
        ST_RX: if (req_valid_i) begin
          unique case (rx_cnt_q)
            2'd0: begin dw0_q <= req_dw_i; rx_cnt_q <= 2'd1; end
            2'd1: begin dw1_q <= req_dw_i; rx_cnt_q <= 2'd2; end
            2'd2: begin
              dw2_q <= req_dw_i;
              if (dw0_q[30]) rx_cnt_q <= 2'd3;
              else begin rx_cnt_q <= 2'd0; state_q <= ST_EXEC; end
            end
            default: begin wdata_q <= req_dw_i; rx_cnt_q <= 2'd0; state_q <= ST_EXEC; end
          endcase
        end
        ST_EXEC: begin
          status_q <= exec_status;
          data_q   <= is_rd && (exec_status == CPL_SC);
          rdata_q  <= rd_mux;
          tx_cnt_q <= '0;
          state_q  <= ST_TX;
          if (is_wr && !malformed) begin
            own_bus_q <= dw2_q[31:24];
            own_dev_q <= dw2_q[23:19];
          end
        end
        default: if (cpl_ready_i) begin
          if (cpl_last_o) state_q <= ST_RX;
          else tx_cnt_q <= tx_cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_RX);
  assign cpl_valid_o = (state_q == ST_TX);
  assign cpl_last_o  = cpl_valid_o && (tx_cnt_q == (data_q ? 2'd3 : 2'd2));

  always_comb begin
    unique case (tx_cnt_q)
      2'd0: cpl_dw_o = {data_q ? FMT_DATA : FMT_NODATA, TYPE_CPL, 14'd0, data_q ? 10'd1 : 10'd0};
      2'd1: cpl_dw_o = {own_bus_q, own_dev_q, FUNC_NUM, status_q, 1'b0, 12'd4};
      2'd2: cpl_dw_o = {dw1_q[31:16], dw1_q[15:8], 1'b0, 7'd0};
      default: cpl_dw_o = rdata_q;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{dw0_q[23], dw0_q[19:10], dw2_q[18:12], dw2_q[1:0]};

  // R11: a stalled completion word holds
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && !cpl_ready_i) |=> (cpl_valid_o && $stable(cpl_dw_o) && $stable(cpl_last_o)));
  // R6: identity follows the target fields of a well-formed write
  p_id_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && is_wr && !malformed) |=>
      (own_bus_q == $past(dw2_q[31:24]) && own_dev_q == $past(dw2_q[23:19])));
  // R5: before readiness only retry, never data
  p_crs_until_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && !ready) |=> (status_q == CPL_CRS && !data_q));
  // R10: UR completions carry no data
  p_ur_nodata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && status_q == CPL_UR) |-> !data_q);
endmodule

// File: tb/cfg_completer_tb.sv
module cfg_completer_tb;
  localparam int          RC      = 300;
  localparam logic [2:0]  FUNC    = 3'd2;
  localparam logic [31:0] IDW     = 32'h5A17_0F3E;
  localparam int          NS      = 4;
  localparam int          CB      = 16;
  localparam int          EB      = 256;

  logic clk = 1'b0, rst_ni = 1'b0, dev_ready_i = 1'b0;
  logic [31:0] req_dw_i = '0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [31:0] cpl_dw_o;
  logic cpl_valid_o, cpl_last_o, cpl_ready_i = 1'b0;

  always #10 clk = ~clk;

  cfg_completer #(.READY_CYCLES(RC), .FUNC_NUM(FUNC), .ID_WORD(IDW), .N_SCR(NS),
                  .COMPAT_BASE(CB), .EXT_BASE(EB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dev_ready_i(dev_ready_i),
    .req_dw_i(req_dw_i), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .cpl_dw_o(cpl_dw_o), .cpl_valid_o(cpl_valid_o), .cpl_last_o(cpl_last_o),
    .cpl_ready_i(cpl_ready_i));

  logic [32:0] exp_q[$];
  string       tag_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_cmp[NS], m_ext[NS];
  logic [7:0]  m_bus;
  logic [4:0]  m_dev;
  bit          m_ready;

  task automatic chk(bit ok, string req, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(int idx);
    if (idx == 0) return IDW;
    if (idx >= CB && idx < CB + NS) return m_cmp[idx-CB];
    if (idx >= EB && idx < EB + NS) return m_ext[idx-EB];
    return 32'h0;
  endfunction

  task automatic model_wr(int idx, logic [3:0] be, logic [31:0] d);
    for (int b = 0; b < 4; b++) if (be[b]) begin
      if (idx >= CB && idx < CB + NS) m_cmp[idx-CB][8*b +: 8] = d[8*b +: 8];
      if (idx >= EB && idx < EB + NS) m_ext[idx-EB][8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin m_cmp[i] = '0; m_ext[i] = '0; end
    m_bus = '0; m_dev = '0;
  endtask

  task automatic push_cpl(logic [2:0] st, bit data, logic [15:0] rid, logic [7:0] tag,
                          logic [31:0] d, string req);
    exp_q.push_back({1'b0, data ? 32'h4A00_0001 : 32'h0A00_0000}); tag_q.push_back(req);
    exp_q.push_back({1'b0, m_bus, m_dev, FUNC, st, 1'b0, 12'd4});    tag_q.push_back(req);
    exp_q.push_back({!data, rid, tag, 8'h00});                       tag_q.push_back(req);
    if (data) begin exp_q.push_back({1'b1, d}); tag_q.push_back(req); end
  endtask

  task automatic drive_dw(logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_dw_i    = d;
    while (!req_ready_o) @(negedge clk);
  endtask

  task automatic send(logic [2:0] fmt, logic [4:0] typ, logic [2:0] tc, logic [9:0] len,
                      logic [15:0] rid, logic [7:0] tag, logic [3:0] lbe, logic [3:0] fbe,
                      int idx, logic [7:0] bus, logic [4:0] dev, logic [31:0] wd);
    logic [9:0] ix;
    ix = 10'(idx);
    drive_dw({fmt, typ, 1'b0, tc, 10'd0, len});
    drive_dw({rid, tag, lbe, fbe});
    drive_dw({bus, dev, 3'b000, 4'b0000, ix[9:6], ix[5:0], 2'b00});
    if (fmt[1]) drive_dw(wd);
    @(negedge clk);
    req_valid_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic rd(int idx, logic [15:0] rid, logic [7:0] tag, string req);
    push_cpl(m_ready ? 3'b000 : 3'b010, m_ready, rid, tag, model_rd(idx), req);
    send(3'b000, 5'b00100, 3'd0, 10'd1, rid, tag, 4'h0, 4'hF, idx, 8'h00, 5'd0, 32'h0);
  endtask

  task automatic wr(int idx, logic [3:0] be, logic [31:0] d, logic [7:0] bus, logic [4:0] dev,
                    logic [15:0] rid, logic [7:0] tag, string req);
    m_bus = bus; m_dev = dev;
    if (m_ready) model_wr(idx, be, d);
    push_cpl(m_ready ? 3'b000 : 3'b010, 1'b0, rid, tag, 32'h0, req);
    send(3'b010, 5'b00100, 3'd0, 10'd1, rid, tag, 4'h0, be, idx, bus, dev, d);
  endtask

  task automatic bad(logic [2:0] fmt, logic [4:0] typ, logic [2:0] tc, logic [9:0] len,
                     logic [3:0] lbe, int idx, logic [15:0] rid, logic [7:0] tag, string req);
    push_cpl(m_ready ? 3'b001 : 3'b010, 1'b0, rid, tag, 32'h0, req);
    send(fmt, typ, tc, len, rid, tag, lbe, 4'hF, idx, 8'hEE, 5'd31, 32'hFFFF_FFFF);
  endtask

  // monitor: pick backpressure, then score any handshake at the coming edge
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      cpl_ready_i = ((cyc % 7) != 2) && ((cyc % 11) != 5);
      if (cpl_valid_o && cpl_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected word", {cpl_last_o, cpl_dw_o}, 33'h0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({cpl_last_o, cpl_dw_o} == e, t, {cpl_last_o, cpl_dw_o}, e);
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
  end

  initial begin
    model_reset();
    m_ready = 0;
    repeat (3) @(negedge clk);
    chk(cpl_valid_o == 1'b0, "R1 reset cpl_valid", {32'h0, cpl_valid_o}, 33'h0);
    chk(req_ready_o == 1'b1, "R1 reset req_ready", {32'h0, req_ready_o}, 33'h1);
    rst_ni = 1'b1;

    // not ready: retry, no write, ID still latched
    rd(0, 16'h0100, 8'h01, "R5 retry on read");
    wr(CB, 4'hF, 32'h1111_2222, 8'h12, 5'd5, 16'h0100, 8'h02, "R5 R6 retry on write, ID latch");
    bad(3'b000, 5'b00100, 3'd0, 10'd2, 4'h0, CB, 16'h0100, 8'h03, "R10 retry beats UR");
    repeat (RC + 20) @(negedge clk);
    m_ready = 1;
    rd(CB, 16'h0100, 8'h04, "R5 write under retry did not land");
    rd(0, 16'h0207, 8'h05, "R2 R8 ID word read");

    wr(CB + 1, 4'hF, 32'hDEAD_BEEF, 8'h3A, 5'h11, 16'h0207, 8'h10, "R3 R6 write completion");
    rd(CB + 1, 16'hABCD, 8'hC3, "R2 R4 read back");
    wr(CB + 1, 4'b0101, 32'h1234_5678, 8'h3A, 5'h11, 16'h0207, 8'h11, "R7 partial enables");
    rd(CB + 1, 16'h0207, 8'h12, "R7 merged bytes");
    wr(CB + 1, 4'b0000, 32'hFFFF_FFFF, 8'h3A, 5'h11, 16'h0207, 8'h13, "R7 zero enables");
    rd(CB + 1, 16'h0207, 8'h14, "R7 zero enables kept value");

    wr(EB + 3, 4'hF, 32'hA5A5_0F0F, 8'h3A, 5'h11, 16'h0300, 8'h20, "R8 extended write");
    rd(EB + 3, 16'h0300, 8'h21, "R8 extended read");
    rd(CB + 3, 16'h0300, 8'h22, "R8 regions separate");
    wr(0, 4'hF, 32'h0, 8'h3A, 5'h11, 16'h0300, 8'h23, "R8 index 0 write");
    rd(0, 16'h0300, 8'h24, "R8 index 0 read only");
    wr(63, 4'hF, 32'h7777_7777, 8'h3A, 5'h11, 16'h0300, 8'h25, "R9 unmapped compatible write");
    rd(63, 16'h0300, 8'h26, "R9 unmapped compatible read");
    wr(700, 4'hF, 32'h8888_8888, 8'h3A, 5'h11, 16'h0300, 8'h27, "R9 unmapped extended write");
    rd(700, 16'h0300, 8'h28, "R9 unmapped extended read");

    bad(3'b010, 5'b00100, 3'd0, 10'd2, 4'h0, CB + 2, 16'h0400, 8'h30, "R10 length 2");
    bad(3'b000, 5'b00100, 3'd0, 10'd1, 4'h1, CB + 2, 16'h0400, 8'h31, "R10 last enables");
    bad(3'b010, 5'b00100, 3'd3, 10'd1, 4'h0, CB + 2, 16'h0400, 8'h32, "R10 nonzero TC");
    bad(3'b000, 5'b00101, 3'd0, 10'd1, 4'h0, CB + 2, 16'h0400, 8'h33, "R10 Type 1");
    rd(CB + 2, 16'h0400, 8'h34, "R10 malformed wrote nothing");

    // second reset with ready input held high
    @(negedge clk);
    rst_ni = 1'b0;
    dev_ready_i = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    rd(CB + 1, 16'h0500, 8'h40, "R5 R6 early ready, ID cleared");
    wr(CB + 2, 4'hF, 32'h0BAD_F00D, 8'h01, 5'd2, 16'h0500, 8'h41, "R6 relatch");
    rd(CB + 2, 16'h0500, 8'h42, "R2 R11 final read");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule